// File: doc/BRIEF.md
# Gated Dual-Edge Event Counter

This block counts level changes of an asynchronous input signal during a measurement window. The window is given by a level gate: while the gate is high, every rising and every falling transition of the conditioned input adds one to a running count. A full square-wave period therefore adds two. When the gate drops, the running count is copied to the output with a one-cycle strobe, and counting restarts from zero in the next window. The count divided by the window length gives the average transition rate, which converts directly to a frequency.

Before counting, the raw input passes through a multi-flop synchroniser and then through a programmable glitch filter. The filter accepts a new input level only after the level has held for the programmed number of clock cycles. A setting of zero switches the filter off. The counter saturates at its maximum value and raises a sticky overflow flag, which clears when the next window opens. Turning the count into a frequency and generating the gate are left to the surrounding logic.

Top module: `gated_edge_counter`

## Requirements
- R1: After reset, `cnt_out` is 0, `cnt_vld` is 0 and `cnt_ovf` is 0.
- R2: While `gate_in` is high, each rising and each falling transition of the filtered input adds one to the running count, so N square-wave periods give 2N.
- R3: Transitions that occur while `gate_in` is low are not counted, and they raise no strobe and do not alter `cnt_out`.
- R4: In the cycle after `gate_in` is first sampled low after being high, `cnt_out` takes the window's count and `cnt_vld` is high for exactly one cycle. The next window then counts from zero.
- R5: With `flt_len` = L > 0, an input level that persists for fewer than L consecutive synchronised cycles is ignored. A level that persists for L or more cycles is accepted.
- R6: With `flt_len` = 0, the synchronised input goes to the edge detector unfiltered, so a one-cycle pulse counts as two transitions.
- R7: The running count saturates at 2^CNT_W-1. A transition that arrives at that value sets `cnt_ovf`, and the reported count is 2^CNT_W-1.
- R8: `cnt_ovf` is sticky until the clock edge that first samples `gate_in` high, where it clears.
- R9: `cnt_out` changes only in a cycle in which `cnt_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_async | input | 1 | Raw asynchronous input whose transitions are counted |
| gate_in | input | 1 | Window gate, synchronous to clk; counting is enabled while high |
| flt_len | input | FLT_W | Glitch filter length in clock cycles; 0 disables the filter |
| cnt_out | output | CNT_W | Count of the most recently closed window |
| cnt_vld | output | 1 | One-cycle strobe when `cnt_out` is updated |
| cnt_ovf | output | 1 | Sticky saturation flag for the current or last window |

## Verification
The assertions check the following on every cycle:
- the running count is frozen while the gate is low and never decreases inside a window;
- the overflow flag stays set until a window opens;
- the filter level holds while the input agrees with it, or while a disagreement is still shorter than the programmed length;
- the strobe lasts a single cycle;
- the output count changes only together with the strobe.

Only the bench scenarios can show the end-to-end numbers: transitions counted per window, the exact length at which a pulse starts to pass the filter, the unfiltered path at length zero, and the saturated value with its flag clearing in the next window.

// File: rtl/gec_pkg.sv
package gec_pkg;
   // Saturating increment: returns the value plus one, held at all-ones.
   function automatic logic [31:0] sat_inc(input logic [31:0] val, input logic [31:0] max_val);
      return (val >= max_val) ? max_val : val + 32'd1;
   endfunction
endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("gec_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gec_glitch_filter.sv
module gec_glitch_filter #(
   parameter int FLT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [FLT_W-1:0] len,
   output logic             dout
);
   localparam logic [FLT_W-1:0] ONE = FLT_W'(1);

   logic [FLT_W-1:0] run_q;
   logic             lvl_q;
   logic             bypass;

   assign bypass = (len == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (bypass) begin
         run_q <= '0;
         lvl_q <= din;
      end else if (din == lvl_q) begin
         run_q <= '0;
      end else if (run_q == len - ONE) begin
         run_q <= '0;
         lvl_q <= din;
      end else begin
         run_q <= run_q + ONE;
      end
   end

   assign dout = bypass ? din : lvl_q;

   // R5: an input that agrees with the held level never moves it
   a_r5_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && din == lvl_q) |=> $stable(lvl_q));
   // R5: a disagreement shorter than the length leaves the level unchanged
   a_r5_hold_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && din != lvl_q && run_q != len - ONE) |=> $stable(lvl_q));
endmodule

// File: rtl/gec_window_counter.sv
module gec_window_counter
   import gec_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic             gate_i,
   output logic [CNT_W-1:0] count_o,
   output logic             valid_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             prev_q;
   logic             gate_q;
   logic [CNT_W-1:0] run_q;
   logic             ovf_q;
   logic             toggle;
   logic             win_open;
   logic             win_close;
   logic [CNT_W-1:0] run_inc;

   assign toggle    = lvl_i ^ prev_q;
   assign win_open  = gate_i & ~gate_q;
   assign win_close = ~gate_i & gate_q;
   assign run_inc   = CNT_W'(sat_inc(32'(run_q), 32'(CNT_MAX)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         gate_q  <= 1'b0;
         run_q   <= '0;
         ovf_q   <= 1'b0;
         count_o <= '0;
         valid_o <= 1'b0;
      end else begin
         prev_q  <= lvl_i;
         gate_q  <= gate_i;
         valid_o <= 1'b0;
         if (win_open) begin
            run_q <= toggle ? CNT_W'(1) : '0;
            ovf_q <= 1'b0;
         end else if (gate_i) begin
            if (toggle) begin
               if (run_q == CNT_MAX) ovf_q <= 1'b1;
               run_q <= run_inc;
            end
         end else if (win_close) begin
            count_o <= run_q;
            valid_o <= 1'b1;
            run_q   <= '0;
         end
      end
   end

   assign ovf_o = ovf_q;

   // R3: running count frozen outside a window
   a_r3_frozen_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_i && !gate_q) |=> $stable(run_q));
   // R7: within a window the count never falls (saturation, no wrap)
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_i && gate_q) |=> (run_q >= $past(run_q)));
   // R8: overflow flag sticky until a window opens
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !win_open) |=> ovf_q);
   // R4: strobe lasts a single cycle
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

// File: rtl/gated_edge_counter.sv
module gated_edge_counter #(
   parameter int CNT_W       = 16,
   parameter int FLT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sig_async,
   input  logic             gate_in,
   input  logic [FLT_W-1:0] flt_len,
   output logic [CNT_W-1:0] cnt_out,
   output logic             cnt_vld,
   output logic             cnt_ovf
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("gated_edge_counter: CNT_W must be at least 2");
   end
   if (FLT_W < 1 || FLT_W > 31) begin : g_bad_flt
      $error("gated_edge_counter: FLT_W out of range");
   end

   logic sig_sync;
   logic sig_clean;

   gec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sig_async),
      .dout (sig_sync)
   );

   gec_glitch_filter #(.FLT_W(FLT_W)) u_filter (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sig_sync),
      .len  (flt_len),
      .dout (sig_clean)
   );

   gec_window_counter #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sig_clean),
      .gate_i (gate_in),
      .count_o(cnt_out),
      .valid_o(cnt_vld),
      .ovf_o  (cnt_ovf)
   );

   // R9: the reported count moves only with its strobe
   a_r9_out_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_vld |-> $stable(cnt_out));
endmodule

// File: tb/tb_gated_edge_counter.sv
module tb_gated_edge_counter;
   localparam int CW = 8;
   localparam int FW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sig_async = 1'b0;
   logic          gate_in = 1'b0;
   logic [FW-1:0] flt_len = '0;
   logic [CW-1:0] cnt_out;
   logic          cnt_vld;
   logic          cnt_ovf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int exp_cnt_q[$];
   int exp_ovf_q[$];
   string exp_req_q[$];
   logic prev_vld = 1'b0;

   always #4 clk = ~clk;

   gated_edge_counter #(.CNT_W(CW), .FLT_W(FW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .sig_async(sig_async), .gate_in(gate_in),
      .flt_len(flt_len), .cnt_out(cnt_out), .cnt_vld(cnt_vld), .cnt_ovf(cnt_ovf)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops an expected item at every strobe
   always @(negedge clk) begin
      if (rst_n && cnt_vld) begin
         if (prev_vld) check("R4 strobe width", 2, 1);
         if (exp_cnt_q.size() == 0) begin
            check("R3 unexpected strobe", 1, 0);
         end else begin
            string rq;
            int ec, eo;
            rq = exp_req_q.pop_front();
            ec = exp_cnt_q.pop_front();
            eo = exp_ovf_q.pop_front();
            check({rq, " count"}, int'(cnt_out), ec);
            check({rq, " ovf"}, int'(cnt_ovf), eo);
         end
      end
      prev_vld = cnt_vld;
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulses(input int n, input int hi, input int lo);
      for (int i = 0; i < n; i++) begin
         sig_async = 1'b1; cycles(hi);
         sig_async = 1'b0; cycles(lo);
      end
   endtask

   // Driver: pushes the expected item, then plays one window
   task automatic window(input string req, input int n, input int hi, input int lo,
                         input int exp_c, input int exp_o);
      exp_req_q.push_back(req);
      exp_cnt_q.push_back(exp_c);
      exp_ovf_q.push_back(exp_o);
      @(negedge clk); gate_in = 1'b1;
      cycles(4);
      pulses(n, hi, lo);
      cycles(int'(flt_len) + 6);
      gate_in = 1'b0;
      cycles(4);
   endtask

   initial begin
      cycles(3);
      // R1: reset state
      check("R1 count", int'(cnt_out), 0);
      check("R1 valid", int'(cnt_vld), 0);
      check("R1 ovf", int'(cnt_ovf), 0);
      rst_n = 1'b1;
      cycles(3);

      // R2, R6: unfiltered square wave, one-cycle phases
      flt_len = '0;
      window("R2 square len0", 5, 1, 1, 10, 0);
      window("R6 single-cycle pulse", 1, 1, 3, 2, 0);

      // R2, R5: filtered wave with long phases
      flt_len = 10'd5;
      window("R2 square len5", 3, 7, 7, 6, 0);
      // R4: next window starts from zero
      window("R4 cleared next window", 1, 8, 8, 2, 0);

      // R5: boundary of the filter length
      window("R5 pulse len-1 rejected", 1, 4, 10, 0, 0);
      window("R5 pulse len accepted", 1, 5, 10, 2, 0);

      // R3: transitions with the gate low are ignored
      pulses(3, 8, 8);
      cycles(12);
      check("R3 count unchanged", int'(cnt_out), 2);
      window("R3 window after idle toggles", 2, 8, 8, 4, 0);

      // R7: saturation with overflow flag
      flt_len = '0;
      window("R7 saturate", 150, 1, 1, 255, 1);
      check("R8 ovf held after close", int'(cnt_ovf), 1);

      // R8: flag clears when the next window opens
      @(negedge clk); gate_in = 1'b1;
      @(negedge clk);
      check("R8 ovf cleared at open", int'(cnt_ovf), 0);
      exp_req_q.push_back("R8 window after overflow");
      exp_cnt_q.push_back(4);
      exp_ovf_q.push_back(0);
      cycles(3);
      pulses(2, 2, 2);
      cycles(6);
      gate_in = 1'b0;
      cycles(4);

      check("R4 all windows reported", exp_cnt_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      cycles(100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule